// File: doc/BRIEF.md
# Event Fragment Receive Checker

This block sits on the receive side of a readout link and watches a stream of 128-bit words that make up event fragments. Each fragment is a header word, zero or more payload words and a trailer word, delimited by start and end flags on the input. The words are forwarded unchanged, one cycle later. While they pass, the block validates the framing and content of the fragment and, on the cycle the trailer leaves, raises a one-cycle error vector together with two monitoring fields: the emulator-source class and the event-type class.

Checks cover the begin and end marker bytes, the format version, the word count against the length field in the trailer, a USB CRC16 over the whole fragment (with the CRC and status fields forced to zero), and the source identifier against an expected value supplied on a port. The trailer's truncation status bit is reported as well. A start flag that arrives while a fragment is still open abandons the old fragment and starts checking the new one, which is then marked as a framing failure. Three saturating counters track fragments seen, CRC failures and length failures; a synchronous clear input zeroes them.

Top module: `frag_rx_checker`

## Requirements
- R1: Every input beat appears on the outputs exactly one cycle later with identical data; the output start and end flags are the input flags qualified by the input valid.
- R2: The header's bits [127:120] must equal 0x55 and the trailer's bits [127:120] must equal 0xAA; a mismatch sets error bit 6.
- R3: A start flag arriving while a fragment is open discards the open fragment without a report, starts checking the new fragment, and sets error bit 6 in the new fragment's report.
- R4: Header bits [119:116] must equal the version parameter (default 1); a mismatch sets error bit 5.
- R5: Trailer bits [115:96] hold the total word count including header and trailer; a mismatch with the received count sets error bit 4.
- R6: A USB CRC16 (reflected polynomial 0xA001, initial value 0xFFFF, result inverted) is run over all words of the fragment, each word bit 0 first, with trailer bits [31:0] taken as zero; if the result differs from trailer bits [31:16], error bit 3 is set.
- R7: Header bits [15:0] must equal the exp_source input; a mismatch sets error bit 2.
- R8: Header bits [113:112] are the emulator class (00 real front end, 01 sender emulator, 10 receiver emulator) and appear on mon_emu with the report; value 11 sets error bit 1.
- R9: Header bits [111:96] are the event type; mon_evt shows it when it is 1 to 7 (physics, calibration, test, technical, simulated, traced, error) and 0 for any other value.
- R10: Trailer bit 4 (truncated) is copied to error bit 0.
- R11: err_valid is high for exactly one cycle, together with out_eof of a trailer that closes an open fragment; an end flag with no open fragment gives no report.
- R12: frag_count, crc_err_count and len_err_count add one on each report, on each report with bit 3, and on each report with bit 4 respectively, visible in the same cycle as err_valid, and hold at their maximum instead of wrapping.
- R13: cnt_clear zeroes all three counters at the next edge and takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat is a fragment header |
| in_eof | input | 1 | Beat is a fragment trailer |
| in_data | input | 128 | Input word |
| exp_source | input | SRC_W | Expected source identifier |
| cnt_clear | input | 1 | Synchronous clear of the counters |
| out_valid | output | 1 | Forwarded beat valid |
| out_sof | output | 1 | Forwarded header flag |
| out_eof | output | 1 | Forwarded trailer flag |
| out_data | output | 128 | Forwarded word |
| err_valid | output | 1 | Fragment report strobe |
| err_vec | output | 7 | {marker, version, length, crc, source, emulator, truncated} |
| mon_emu | output | 2 | Emulator class of the reported fragment |
| mon_evt | output | 3 | Event-type class of the reported fragment |
| frag_count | output | CNT_W | Fragments reported |
| crc_err_count | output | CNT_W | Reports with a CRC failure |
| len_err_count | output | CNT_W | Reports with a length failure |

## Verification
Two collisions matter most here: all seven error conditions landing in one trailer's report, and a counter clear arriving on the very edge that a report increments the counters. The bench sweeps every combination of the seven injectable faults over fragments of two, three and four words, so CRC and length faults share reports with every other fault, and each vector bit is judged separately against the injected mask. It then raises cnt_clear during a trailer beat and expects all counters at zero with the report still delivered, and separately opens a fragment and restarts it with a new header to confirm that only the second one reports, with the marker bit set.

// File: rtl/frag_chk_pkg.sv
// Package: shared constants, enums and the CRC step for the fragment
// receive checker. Assumes fixed 128-bit words.
package frag_chk_pkg;

    localparam int WORD_W = 128;
    localparam int VEC_W  = 7;

    localparam logic [7:0] HDR_MARK = 8'h55;
    localparam logic [7:0] TRL_MARK = 8'hAA;

    // error vector bit positions
    localparam int EB_MARK  = 6;
    localparam int EB_VER   = 5;
    localparam int EB_LEN   = 4;
    localparam int EB_CRC   = 3;
    localparam int EB_SRC   = 2;
    localparam int EB_EMU   = 1;
    localparam int EB_TRUNC = 0;

    typedef enum logic [1:0] {
        EMU_REAL   = 2'b00,
        EMU_SENDER = 2'b01,
        EMU_RECV   = 2'b10,
        EMU_BAD    = 2'b11
    } emu_class_e;

    // USB CRC16, reflected form: one 128-bit word, bit 0 first
    function automatic logic [15:0] crc16_word(input logic [15:0] seed,
                                               input logic [WORD_W-1:0] d);
        logic [15:0] c;
        logic        fb;
        c = seed;
        for (int i = 0; i < WORD_W; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[15:1]};
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    // Map a 16-bit event type to a 3-bit class, 0 for unknown codes
    function automatic logic [2:0] evt_class(input logic [15:0] t);
        return (t >= 16'd1 && t <= 16'd7) ? t[2:0] : 3'd0;
    endfunction

endpackage

// File: rtl/frag_crc_acc.sv
// Running CRC over the beats of one fragment. Restarts on a header beat,
// zeroes the CRC and status fields on the trailer beat and compares the
// inverted result with the transmitted CRC. Assumes the caller enables it
// only on beats that belong to a fragment.
module frag_crc_acc
    import frag_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_en,
    input  logic              restart,
    input  logic              last,
    input  logic [WORD_W-1:0] data,
    output logic              crc_match
);

    logic [15:0]       crc_q;
    logic [15:0]       seed;
    logic [15:0]       crc_nxt;
    logic [WORD_W-1:0] data_z;

    // Pick the seed and mask the CRC/status fields of the trailer
    always_comb begin
        seed      = restart ? 16'hFFFF : crc_q;
        data_z    = last ? {data[WORD_W-1:32], 32'h0} : data;
        crc_nxt   = crc16_word(seed, data_z);
        crc_match = (~crc_nxt) == data[31:16];
    end

    // Hold the running CRC between beats
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= 16'hFFFF;
        else if (beat_en) crc_q <= crc_nxt;
    end

endmodule

// File: rtl/frag_track.sv
// Fragment framing tracker. Follows header/trailer flags, counts words,
// holds the header verdicts until the trailer, and forms the report.
// Assumes header fields are sampled on the start beat and trailer fields
// on the end beat; a fresh start beat while open forces a framing error.
module frag_track
    import frag_chk_pkg::*;
#(
    parameter int          LEN_W   = 20,
    parameter int          SRC_W   = 16,
    parameter logic [3:0]  VERSION = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              sof,
    input  logic              eof,
    input  logic [7:0]        marker,
    input  logic [3:0]        ver,
    input  logic [1:0]        emu,
    input  logic [15:0]       evt,
    input  logic [LEN_W-1:0]  len,
    input  logic [SRC_W-1:0]  src,
    input  logic [SRC_W-1:0]  exp_src,
    input  logic              trunc,
    input  logic              crc_ok,
    output logic              in_frag,
    output logic              rpt,
    output logic [VEC_W-1:0]  vec,
    output logic [1:0]        emu_c,
    output logic [2:0]        evt_c
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cnt_cur;
    logic             mark_q, ver_q, src_q, emu_bad_q;
    logic             mark_cur, ver_cur, src_cur, emu_bad_cur;
    logic [1:0]       emu_q;
    logic [2:0]       evt_q;

    // Current-beat view of header verdicts and the word count
    always_comb begin
        if (sof) begin
            mark_cur    = in_frag || (marker != HDR_MARK);
            ver_cur     = ver != VERSION;
            src_cur     = src != exp_src;
            emu_bad_cur = emu == EMU_BAD;
            emu_c       = emu;
            evt_c       = evt_class(evt);
            cnt_cur     = ONE;
        end else begin
            mark_cur    = mark_q;
            ver_cur     = ver_q;
            src_cur     = src_q;
            emu_bad_cur = emu_bad_q;
            emu_c       = emu_q;
            evt_c       = evt_q;
            cnt_cur     = (cnt_q == '1) ? cnt_q : cnt_q + ONE;
        end
    end

    // Report on a trailer that closes a fragment
    always_comb begin
        rpt = valid && eof && (sof || in_frag);
        vec = '0;
        vec[EB_MARK]  = mark_cur || (marker != TRL_MARK);
        vec[EB_VER]   = ver_cur;
        vec[EB_LEN]   = cnt_cur != len;
        vec[EB_CRC]   = !crc_ok;
        vec[EB_SRC]   = src_cur;
        vec[EB_EMU]   = emu_bad_cur;
        vec[EB_TRUNC] = trunc;
    end

    // Track the open fragment and latch header verdicts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frag   <= 1'b0;
            cnt_q     <= '0;
            mark_q    <= 1'b0;
            ver_q     <= 1'b0;
            src_q     <= 1'b0;
            emu_bad_q <= 1'b0;
            emu_q     <= 2'b00;
            evt_q     <= 3'd0;
        end else if (valid && sof) begin
            in_frag   <= !eof;
            cnt_q     <= cnt_cur;
            mark_q    <= mark_cur;
            ver_q     <= ver_cur;
            src_q     <= src_cur;
            emu_bad_q <= emu_bad_cur;
            emu_q     <= emu_c;
            evt_q     <= evt_c;
        end else if (valid && in_frag) begin
            cnt_q <= cnt_cur;
            if (eof) in_frag <= 1'b0;
        end
    end

    // R3
    resync_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sof && !eof) |=> in_frag);

    // R5
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_frag |-> (cnt_q != '0));

endmodule

// File: rtl/frag_sat_cnt.sv
// Saturating event counter with synchronous clear. Assumes the clear
// dominates an increment in the same cycle.
module frag_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count up, stop at all-ones, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (clr)                  count <= '0;
        else if (inc && count != '1)   count <= count + 1'b1;
    end

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == '1) |=> count == '1);

    // R12
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ({1'b0, count} == {1'b0, $past(count)} ||
                  {1'b0, count} == {1'b0, $past(count)} + 1'b1));

    // R13
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

endmodule

// File: rtl/frag_rx_checker.sv
// Top of the fragment receive checker. Forwards the word stream with one
// register stage, runs the framing tracker and CRC accumulator in parallel,
// registers the per-fragment report alongside the trailer, and keeps three
// saturating counters. Assumes well-formed valid/flag timing from the link.
module frag_rx_checker
    import frag_chk_pkg::*;
#(
    parameter int         CNT_W   = 16,
    parameter int         LEN_W   = 20,
    parameter int         SRC_W   = 16,
    parameter logic [3:0] VERSION = 4'h1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [127:0]       in_data,
    input  logic [SRC_W-1:0]   exp_source,
    input  logic               cnt_clear,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_eof,
    output logic [127:0]       out_data,
    output logic               err_valid,
    output logic [6:0]         err_vec,
    output logic [1:0]         mon_emu,
    output logic [2:0]         mon_evt,
    output logic [CNT_W-1:0]   frag_count,
    output logic [CNT_W-1:0]   crc_err_count,
    output logic [CNT_W-1:0]   len_err_count
);

    localparam int LEN_LSB = 96;
    localparam int N_CNT   = 3;

    logic             in_frag;
    logic             crc_ok;
    logic             rpt;
    logic [VEC_W-1:0] vec;
    logic [1:0]       emu_c;
    logic [2:0]       evt_c;
    logic [N_CNT-1:0] inc_v;
    logic [CNT_W-1:0] cnt_arr [N_CNT];

    frag_crc_acc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_en   (in_valid && (in_sof || in_frag)),
        .restart   (in_sof),
        .last      (in_eof),
        .data      (in_data),
        .crc_match (crc_ok)
    );

    frag_track #(
        .LEN_W   (LEN_W),
        .SRC_W   (SRC_W),
        .VERSION (VERSION)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (in_valid),
        .sof     (in_sof),
        .eof     (in_eof),
        .marker  (in_data[127:120]),
        .ver     (in_data[119:116]),
        .emu     (in_data[113:112]),
        .evt     (in_data[111:96]),
        .len     (in_data[LEN_LSB+LEN_W-1:LEN_LSB]),
        .src     (in_data[SRC_W-1:0]),
        .exp_src (exp_source),
        .trunc   (in_data[4]),
        .crc_ok  (crc_ok),
        .in_frag (in_frag),
        .rpt     (rpt),
        .vec     (vec),
        .emu_c   (emu_c),
        .evt_c   (evt_c)
    );

    // Forward the stream one cycle later, unchanged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_eof   <= in_valid && in_eof;
            out_data  <= in_data;
        end
    end

    // Register the fragment report next to its trailer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_vec   <= '0;
            mon_emu   <= 2'b00;
            mon_evt   <= 3'd0;
        end else begin
            err_valid <= rpt;
            err_vec   <= rpt ? vec   : '0;
            mon_emu   <= rpt ? emu_c : 2'b00;
            mon_evt   <= rpt ? evt_c : 3'd0;
        end
    end

    assign inc_v = {rpt && vec[EB_LEN], rpt && vec[EB_CRC], rpt};

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
            frag_sat_cnt #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (cnt_clear),
                .inc   (inc_v[g]),
                .count (cnt_arr[g])
            );
        end
    endgenerate

    assign frag_count    = cnt_arr[0];
    assign crc_err_count = cnt_arr[1];
    assign len_err_count = cnt_arr[2];

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data)));

    // R11
    report_on_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (out_valid && out_eof));

    // R11
    report_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !in_valid) |=> !err_valid);

    // R8
    emu_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && mon_emu == 2'b11) |-> err_vec[1]);

endmodule

// File: tb/tb_frag_rx_checker.sv
// Sweeps every fault combination over short fragments, plus restart,
// stray trailer, counter saturation and clear-priority cases.
module tb_frag_rx_checker;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int CMAX       = (1 << CNT_W) - 1;
    localparam logic [15:0] SRC_OK = 16'h3A5C;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid, in_sof, in_eof;
    logic [127:0]       in_data;
    logic [15:0]        exp_source;
    logic               cnt_clear;
    logic               out_valid, out_sof, out_eof;
    logic [127:0]       out_data;
    logic               err_valid;
    logic [6:0]         err_vec;
    logic [1:0]         mon_emu;
    logic [2:0]         mon_evt;
    logic [CNT_W-1:0]   frag_count, crc_err_count, len_err_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int ef = 0, ec = 0, el = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frag_rx_checker #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .exp_source(exp_source),
        .cnt_clear(cnt_clear), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_data(out_data), .err_valid(err_valid),
        .err_vec(err_vec), .mon_emu(mon_emu), .mon_evt(mon_evt),
        .frag_count(frag_count), .crc_err_count(crc_err_count),
        .len_err_count(len_err_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // byte-wise reference of the reflected CRC
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [127:0] w);
        logic [15:0] r = c;
        for (int b = 0; b < 16; b++) begin
            r = r ^ {8'h00, w[8*b +: 8]};
            for (int k = 0; k < 8; k++)
                r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        end
        return r;
    endfunction

    task automatic chk_counters(input string tag);
        chk(frag_count == CNT_W'(ef), tag, "frag_count", frag_count, ef);
        chk(crc_err_count == CNT_W'(ec), tag, "crc_err_count", crc_err_count, ec);
        chk(len_err_count == CNT_W'(el), tag, "len_err_count", len_err_count, el);
    endtask

    task automatic beat(input bit s, input bit e, input logic [127:0] d,
                        input bit rpt, input logic [6:0] ev,
                        input logic [1:0] emu, input logic [2:0] evt);
        string nm [7] = '{"R10", "R8", "R7", "R6", "R5", "R4", "R2"};
        in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
        @(negedge clk);
        chk(out_valid === 1'b1 && out_sof === s && out_eof === e, "R1", "flags",
            {out_valid, out_sof, out_eof}, {1'b1, s, e});
        chk(out_data === d, "R1", "data", out_data, d);
        chk(err_valid === rpt, "R11", "err_valid", err_valid, rpt);
        if (rpt) begin
            for (int b = 0; b < 7; b++)
                chk(err_vec[b] === ev[b], nm[b], $sformatf("err_vec[%0d]", b),
                    err_vec[b], ev[b]);
            chk(mon_emu === emu, "R8", "mon_emu", mon_emu, emu);
            chk(mon_evt === evt, "R9", "mon_evt", mon_evt, evt);
            if (cnt_clear) begin
                ef = 0; ec = 0; el = 0;
                chk_counters("R13");
            end else begin
                if (ef < CMAX) ef++;
                if (ev[3] && ec < CMAX) ec++;
                if (ev[4] && el < CMAX) el++;
                chk_counters("R12");
            end
        end
    endtask

    task automatic idle();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1", "idle out_valid", out_valid, 0);
        chk(err_valid === 1'b0, "R11", "idle err_valid", err_valid, 0);
    endtask

    // mask bits: 6 marker, 5 version, 4 length, 3 crc, 2 source, 1 emu, 0 trunc
    task automatic send_frag(input int nw, input int mask, input int tsel,
                             input logic [6:0] extra, input bit clr_last);
        logic [127:0] w [8];
        logic [127:0] t;
        logic [15:0]  c;
        logic [1:0]   emu;
        logic [2:0]   exp_evt;
        emu     = mask[1] ? 2'b11 : 2'((mask >> 2) % 3);
        exp_evt = (tsel >= 1 && tsel <= 7) ? 3'(tsel) : 3'd0;
        w[0] = '0;
        w[0][127:120] = (mask[6] && (nw % 2 == 0)) ? 8'h54 : 8'h55;
        w[0][119:116] = mask[5] ? 4'h2 : 4'h1;
        w[0][113:112] = emu;
        w[0][111:96]  = (tsel == 8) ? 16'h8001 : 16'(tsel);
        w[0][63:32]   = 32'(mask * 977 + nw);
        w[0][15:0]    = mask[2] ? (SRC_OK ^ 16'h0001) : SRC_OK;
        for (int i = 1; i < nw - 1; i++)
            w[i] = {32'(i * 7919 + mask), 32'hC0DE0000 | 32'(i), 32'(mask * 31), 32'(nw)};
        t = '0;
        t[127:120] = (mask[6] && (nw % 2 == 1)) ? 8'hAB : 8'hAA;
        t[115:96]  = 20'(mask[4] ? nw + 1 : nw);
        t[63:40]   = 24'h0ABC00 + 24'(mask);
        c = 16'hFFFF;
        for (int i = 0; i < nw - 1; i++) c = ref_crc(c, w[i]);
        c = ref_crc(c, t);
        c = ~c;
        if (mask[3]) c = c ^ 16'h0100;
        t[31:16] = c;
        t[15:0]  = mask[0] ? 16'h0013 : 16'h0003;
        w[nw-1]  = t;
        for (int i = 0; i < nw; i++) begin
            if (i == nw - 1 && clr_last) cnt_clear = 1'b1;
            beat(i == 0, i == nw - 1, w[i], i == nw - 1, 7'(mask) | extra, emu, exp_evt);
            cnt_clear = 1'b0;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data = '0; exp_source = SRC_OK; cnt_clear = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && err_valid === 1'b0, "R1", "reset outputs",
            {out_valid, err_valid}, 0);
        chk_counters("R12");
        rst_n = 1'b1;
        @(negedge clk);

        // R11: trailer with no open fragment gives no report
        beat(1'b0, 1'b1, {8'hAA, 120'h5}, 1'b0, '0, '0, '0);
        idle();

        // R2..R10 sweep: every fault mask over 2, 3 and 4 word fragments
        for (int nw = 2; nw <= 4; nw++) begin
            for (int m = 0; m < 128; m++) begin
                send_frag(nw, m, (m + nw) % 9, 7'h00, 1'b0);
                idle();
            end
            chk_counters("R12");
        end

        // R13: plain clear pulse
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        ef = 0; ec = 0; el = 0;
        chk_counters("R13");

        // R3: restart while open, then a clean fragment flagged as marker fault
        beat(1'b1, 1'b0, {8'h55, 4'h1, 20'h00001, 80'h0, SRC_OK}, 1'b0, '0, '0, '0);
        beat(1'b0, 1'b0, 128'hDEAD_BEEF, 1'b0, '0, '0, '0);
        send_frag(3, 0, 2, 7'h40, 1'b0);
        idle();
        send_frag(2, 0, 1, 7'h00, 1'b0);
        idle();

        // R13: clear on the same edge as a reporting trailer
        send_frag(3, 8'h18, 4, 7'h00, 1'b1);
        idle();
        chk_counters("R13");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule